// File: doc/BRIEF.md
# Four-Conversion SAR ADC Sequencer

This block is the digital control side of an 8-bit successive-approximation analog-to-digital converter. One start strobe launches a sequence of four conversions on four consecutive analog channels, counted from a base channel number. Each conversion runs on a fixed frame of conversion-clock cycles. The frame opens with a sample window and a short hold gap. Then come two cycles for each bit, starting at the most significant bit. For every bit the block presents a trial code to an external DAC and reads back one comparator decision. The finished code goes into the result register that belongs to that conversion's position in the sequence.

The conversion clock is given as an enable that qualifies the block clock. Which oscillator produces that enable is decided outside the block. A completion flag rises once the fourth result has been stored. In single mode the sequencer then goes idle. In continuous mode it starts the next pass straight away, overwrites the result registers, and leaves the flag set. The four result registers can be read at any time through a select and data port. Each register changes in one clock edge, so a read never returns a code that is only partly updated.

Top module: `sar_seq4`

## Requirements
- R1: When `start` is high at a clock edge, any sequence in progress is abandoned. This applies whether or not `cnv_en` is high. `seq_done` clears, and from the next cycle the block is running at conversion index 0, frame cycle 0, with the approximation register at zero.
- R2: Conversion index i (0..3) writes result register i at the enabled edge that ends its frame. `rd_data` shows register `rd_sel` combinationally. All registers read 0 until they are written.
- R3: A frame counter advances only at edges where `cnv_en` is high. A conversion takes 32 enabled cycles and a full sequence takes 128. `seq_done` is first seen in the cycle after the 128th enabled edge that follows the start edge.
- R4: `samp_en` is high exactly during frame cycles 0 to 11 of a running conversion. It is low at all other times, including cycles 12 to 15 (the hold gap) and while idle.
- R5: `ch_sel` equals `base_ch` plus the conversion index, modulo 8. When idle, the index is 0.
- R6: During frame cycles 16+2j and 17+2j (j = 0..7), `trial_code` holds the bits already resolved with a 1 at bit position 7-j, and zeros below that position. In cycles 0 to 15 and while idle, `trial_code` is 0.
- R7: At the enabled edge that ends cycle 17+2j, bit 7-j is kept as 1 if `cmp_ge` is high (input at or above the trial level) and cleared otherwise. A stable input level v therefore yields the code v.
- R8: `seq_done` is set at the edge that stores the fourth result. It then stays set, in both modes, until the next start strobe.
- R9: With `cont_mode` low at the sequence's last edge, the block goes idle after the fourth conversion and the results stay unchanged afterwards. With `cont_mode` high, conversion index 0 begins again at frame cycle 0.
- R10: After reset the block is idle: `seq_done`, `samp_en` and `trial_code` are 0, and every result register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_en | input | 1 | Conversion-clock enable; one frame cycle per high edge |
| start | input | 1 | Start or restart strobe |
| cont_mode | input | 1 | 1 = repeat sequences, 0 = one sequence |
| base_ch | input | 3 | First channel of the sequence |
| cmp_ge | input | 1 | Comparator: analog input at or above the trial level |
| samp_en | output | 1 | Sample window active |
| ch_sel | output | 3 | Analog channel being converted |
| trial_code | output | 8 | Code driven to the DAC |
| rd_sel | input | 2 | Result register select |
| rd_data | output | 8 | Selected result register |
| seq_done | output | 1 | All four results are valid |

## Verification
`samp_en`, `ch_sel` and `trial_code` are due in the same cycle as the frame state that drives them. A bit decision shows up in `trial_code` in the cycle after the enabled edge that closes its slot. A result reaches `rd_data` in the cycle after the last bit's edge, and `seq_done` rises together with the fourth result. The bench keeps a behavioural model that steps once per clock with the same inputs the design sees. It samples every output at the falling edge and compares it with the model, so each result is checked in exactly the cycle it is due. Separate checks count the enabled edges from start to flag (128) and compare the stored codes against the modelled analog levels.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_HOLD   = 2'd2,
      PH_BITS   = 2'd3
   } phase_e;

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
   import sar_seq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_CONV   = 4,
   parameter int SAMPLE_CYC = 12,
   parameter int GAP_CYC    = 4,
   parameter int BIT_CYC    = 2,
   parameter int CYC_W      = 5,
   parameter int CONV_W     = 2,
   parameter int IDX_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_en,
   input  logic              start,
   input  logic              cont_mode,
   output phase_e            phase,
   output logic [CONV_W-1:0] conv_idx,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              decide,
   output logic              tick,
   output logic              conv_end,
   output logic              seq_end_tick
);

   localparam int FRAME      = SAMPLE_CYC + GAP_CYC + DATA_W * BIT_CYC;
   localparam int BITS_START = SAMPLE_CYC + GAP_CYC;
   localparam logic [CYC_W-1:0]  LAST_CYC   = CYC_W'(FRAME - 1);
   localparam logic [CYC_W-1:0]  SAMP_END   = CYC_W'(SAMPLE_CYC);
   localparam logic [CYC_W-1:0]  BITS_C     = CYC_W'(BITS_START);
   localparam logic [CYC_W-1:0]  MSB_C      = CYC_W'(DATA_W - 1);
   localparam logic [CONV_W-1:0] LAST_CONV  = CONV_W'(NUM_CONV - 1);
   localparam logic [CYC_W-1:0]  SLOT_MASK  = CYC_W'(BIT_CYC - 1);

   logic              run_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [CONV_W-1:0] conv_q;
   logic [CYC_W-1:0]  off;
   logic [CYC_W-1:0]  slot;
   logic              last_conv;

   assign tick         = run_q & cnv_en & ~start;
   assign conv_end     = (cyc_q == LAST_CYC);
   assign last_conv    = (conv_q == LAST_CONV);
   assign seq_end_tick = tick & conv_end & last_conv;
   assign conv_idx     = conv_q;
   assign off          = cyc_q - BITS_C;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cyc_q  <= '0;
         conv_q <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         cyc_q  <= '0;
         conv_q <= '0;
      end else if (tick) begin
         if (conv_end) begin
            cyc_q <= '0;
            if (last_conv) begin
               conv_q <= '0;
               run_q  <= cont_mode;
            end else begin
               conv_q <= conv_q + 1'b1;
            end
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (!run_q)               phase = PH_IDLE;
      else if (cyc_q < SAMP_END) phase = PH_SAMPLE;
      else if (cyc_q < BITS_C)   phase = PH_HOLD;
      else                       phase = PH_BITS;
   end

   // Slot decode: shift/mask when the bit time is a power of two, divide otherwise.
   generate
      if ((BIT_CYC & (BIT_CYC - 1)) == 0) begin : g_slot_pow2
         localparam int SH = $clog2(BIT_CYC);
         assign slot   = off >> SH;
         assign decide = ((off & SLOT_MASK) == SLOT_MASK);
      end else begin : g_slot_div
         localparam logic [CYC_W-1:0] BC = CYC_W'(BIT_CYC);
         assign slot   = off / BC;
         assign decide = ((off % BC) == SLOT_MASK);
      end
   endgenerate

   assign bit_idx = IDX_W'(MSB_C - slot);

   a_r1_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (run_q && cyc_q == '0 && conv_q == '0));

   a_r3_freeze_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnv_en && !start) |=> ($stable(cyc_q) && $stable(conv_q) && $stable(run_q)));

   a_r9_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end_tick && !cont_mode) |=> !run_q);

   a_r9_cont_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end_tick && cont_mode) |=> (run_q && conv_q == '0 && cyc_q == '0));

endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx
   import sar_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic              conv_end,
   input  phase_e            phase,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              decide,
   input  logic              cmp_ge,
   output logic [DATA_W-1:0] trial_code,
   output logic [DATA_W-1:0] final_code
);

   logic [DATA_W-1:0] sar_q;
   logic [DATA_W-1:0] cur_bit;
   logic [DATA_W-1:0] kept_bit;

   assign cur_bit  = DATA_W'(1) << bit_idx;
   assign kept_bit = cmp_ge ? cur_bit : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sar_q <= '0;
      end else if (start || (tick && conv_end)) begin
         sar_q <= '0;
      end else if (tick && decide && phase == PH_BITS) begin
         sar_q <= sar_q | kept_bit;
      end
   end

   assign trial_code = (phase == PH_BITS) ? (sar_q | cur_bit) : '0;
   // Code as it stands after the decision made on the current edge.
   assign final_code = sar_q | kept_bit;

   a_r7_clear_in_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SAMPLE) |-> (sar_q == '0));

   a_r7_hold_outside_decide: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !(tick && (decide || conv_end))) |=> $stable(sar_q));

endmodule

// File: rtl/sar_seq_results.sv
module sar_seq_results #(
   parameter int DATA_W   = 8,
   parameter int NUM_CONV = 4,
   parameter int CONV_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CONV_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CONV_W-1:0] rd_sel,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0]   res_q [NUM_CONV];
   logic [NUM_CONV-1:0] wr_vec;

   generate
      for (genvar g = 0; g < NUM_CONV; g++) begin : g_reg
         assign wr_vec[g] = wr_en && (wr_idx == CONV_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         res_q[g] <= '0;
            else if (wr_vec[g]) res_q[g] <= wr_data;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CONV; i++) begin
         if (rd_sel == CONV_W'(i)) rd_data = res_q[i];
      end
   end

   a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec));

endmodule

// File: rtl/sar_seq4.sv
module sar_seq4
   import sar_seq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_CONV   = 4,
   parameter int CH_W       = 3,
   parameter int SAMPLE_CYC = 12,
   parameter int GAP_CYC    = 4,
   parameter int BIT_CYC    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cnv_en,
   input  logic                         start,
   input  logic                         cont_mode,
   input  logic [CH_W-1:0]              base_ch,
   input  logic                         cmp_ge,
   output logic                         samp_en,
   output logic [CH_W-1:0]              ch_sel,
   output logic [DATA_W-1:0]            trial_code,
   input  logic [$clog2(NUM_CONV)-1:0]  rd_sel,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         seq_done
);

   localparam int FRAME  = SAMPLE_CYC + GAP_CYC + DATA_W * BIT_CYC;
   localparam int CYC_W  = $clog2(FRAME);
   localparam int CONV_W = $clog2(NUM_CONV);
   localparam int IDX_W  = $clog2(DATA_W);

   generate
      if (DATA_W < 2)     begin : g_bad_width  $error("DATA_W must be at least 2");     end
      if (NUM_CONV < 2)   begin : g_bad_conv   $error("NUM_CONV must be at least 2");   end
      if (SAMPLE_CYC < 1) begin : g_bad_sample $error("SAMPLE_CYC must be at least 1"); end
      if (BIT_CYC < 1)    begin : g_bad_bit    $error("BIT_CYC must be at least 1");    end
      if (CH_W < 1)       begin : g_bad_ch     $error("CH_W must be at least 1");       end
   endgenerate

   phase_e            phase;
   logic [CONV_W-1:0] conv_idx;
   logic [IDX_W-1:0]  bit_idx;
   logic              decide;
   logic              tick;
   logic              conv_end;
   logic              seq_end_tick;
   logic [DATA_W-1:0] final_code;
   logic              done_q;

   sar_seq_timer #(
      .DATA_W     (DATA_W),
      .NUM_CONV   (NUM_CONV),
      .SAMPLE_CYC (SAMPLE_CYC),
      .GAP_CYC    (GAP_CYC),
      .BIT_CYC    (BIT_CYC),
      .CYC_W      (CYC_W),
      .CONV_W     (CONV_W),
      .IDX_W      (IDX_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .cnv_en       (cnv_en),
      .start        (start),
      .cont_mode    (cont_mode),
      .phase        (phase),
      .conv_idx     (conv_idx),
      .bit_idx      (bit_idx),
      .decide       (decide),
      .tick         (tick),
      .conv_end     (conv_end),
      .seq_end_tick (seq_end_tick)
   );

   sar_seq_approx #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_approx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .tick       (tick),
      .conv_end   (conv_end),
      .phase      (phase),
      .bit_idx    (bit_idx),
      .decide     (decide),
      .cmp_ge     (cmp_ge),
      .trial_code (trial_code),
      .final_code (final_code)
   );

   sar_seq_results #(
      .DATA_W   (DATA_W),
      .NUM_CONV (NUM_CONV),
      .CONV_W   (CONV_W)
   ) u_results (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tick & conv_end),
      .wr_idx  (conv_idx),
      .wr_data (final_code),
      .rd_sel  (rd_sel),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            done_q <= 1'b0;
      else if (start)        done_q <= 1'b0;
      else if (seq_end_tick) done_q <= 1'b1;
   end

   assign seq_done = done_q;
   assign samp_en  = (phase == PH_SAMPLE);
   assign ch_sel   = base_ch + CH_W'(conv_idx);

   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !start) |=> seq_done);

   a_r8_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end_tick |=> seq_done);

   a_r4_no_sample_with_trial: assert property (@(posedge clk) disable iff (!rst_n)
      samp_en |-> (trial_code == '0));

endmodule

// File: tb/sar_seq4_tb.sv
module sar_seq4_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnv_en = 1'b0;
   logic       start = 1'b0;
   logic       cont_mode = 1'b0;
   logic [2:0] base_ch = 3'd0;
   logic       cmp_ge;
   logic       samp_en;
   logic [2:0] ch_sel;
   logic [7:0] trial_code;
   logic [1:0] rd_sel = 2'd0;
   logic [7:0] rd_data;
   logic       seq_done;

   logic [7:0] vin [8];
   logic [7:0] nxt_vin [8];
   logic [2:0] nxt_base = 3'd0;
   logic       nxt_cont = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   // model state
   int m_run = 0, m_cyc = 0, m_conv = 0, m_sar = 0, m_done = 0;
   int m_res [4];
   bit last_done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign cmp_ge = (vin[ch_sel] >= trial_code);

   sar_seq4 u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnv_en     (cnv_en),
      .start      (start),
      .cont_mode  (cont_mode),
      .base_ch    (base_ch),
      .cmp_ge     (cmp_ge),
      .samp_en    (samp_en),
      .ch_sel     (ch_sel),
      .trial_code (trial_code),
      .rd_sel     (rd_sel),
      .rd_data    (rd_data),
      .seq_done   (seq_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   function automatic int m_trial();
      if (m_run != 0 && m_cyc >= 16) return m_sar | (1 << (7 - (m_cyc - 16) / 2));
      return 0;
   endfunction

   task automatic compare();
      chk("R4 samp_en", int'(samp_en), (m_run != 0 && m_cyc < 12) ? 1 : 0);
      chk("R5 ch_sel", int'(ch_sel), (int'(base_ch) + m_conv) % 8);
      chk("R6 trial_code", int'(trial_code), m_trial());
      chk("R8 seq_done", int'(seq_done), m_done);
      chk("R2 rd_data", int'(rd_data), m_res[rd_sel]);
   endtask

   task automatic model_next(input bit st, input bit en);
      int lvl, tr;
      if (st) begin
         m_run = 1; m_cyc = 0; m_conv = 0; m_sar = 0; m_done = 0;
      end else if (m_run != 0 && en) begin
         if (m_cyc >= 16 && ((m_cyc - 16) % 2) == 1) begin
            lvl = int'(vin[(int'(base_ch) + m_conv) % 8]);
            tr  = m_trial();
            if (lvl >= tr) m_sar = tr;
         end
         if (m_cyc == 31) begin
            m_res[m_conv] = m_sar;
            m_sar = 0;
            m_cyc = 0;
            if (m_conv == 3) begin
               m_conv = 0;
               m_done = 1;
               if (!cont_mode) m_run = 0;
            end else begin
               m_conv++;
            end
         end else begin
            m_cyc++;
         end
      end
   endtask

   // one clock: compare current outputs, then present inputs for the next edge
   task automatic step(input bit st, input bit en);
      @(negedge clk);
      compare();
      last_done = seq_done;
      base_ch   = nxt_base;
      cont_mode = nxt_cont;
      for (int i = 0; i < 8; i++) vin[i] = nxt_vin[i];
      start  = st;
      cnv_en = en;
      rd_sel = rd_sel + 2'd1;
      model_next(st, en);
   endtask

   task automatic read_reg(input int idx, output int val);
      @(negedge clk);
      compare();
      rd_sel = 2'(idx);
      start  = 1'b0;
      model_next(1'b0, cnv_en);
      @(negedge clk);
      compare();
      val = int'(rd_data);
      model_next(1'b0, cnv_en);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
         summary();
      end
   end

   initial begin
      int k, v;
      for (int i = 0; i < 4; i++) m_res[i] = 0;
      for (int i = 0; i < 8; i++) begin vin[i] = 8'd0; nxt_vin[i] = 8'd0; end

      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 seq_done", int'(seq_done), 0);
      chk("R10 samp_en", int'(samp_en), 0);
      chk("R10 trial_code", int'(trial_code), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         read_reg(i, v);
         chk("R10 result reg", v, 0);
      end

      // Single pass, base 0, full enable
      nxt_vin[0] = 8'd0; nxt_vin[1] = 8'd255; nxt_vin[2] = 8'd128; nxt_vin[3] = 8'd77;
      nxt_base = 3'd0; nxt_cont = 1'b0;
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      k = 0;
      last_done = 0;
      while (!last_done && k < 300) begin
         step(1'b0, 1'b1);
         k++;
      end
      chk("R3 enabled edges to done (plus one)", k, 129);
      repeat (10) step(1'b0, 1'b1);
      chk("R9 idle after single pass", int'(samp_en), 0);
      read_reg(0, v); chk("R7 code ch0", v, 0);
      read_reg(1, v); chk("R7 code ch1", v, 255);
      read_reg(2, v); chk("R7 code ch2", v, 128);
      read_reg(3, v); chk("R7 code ch3", v, 77);
      // inputs change after stop: results must stay
      nxt_vin[1] = 8'd3;
      repeat (40) step(1'b0, 1'b1);
      read_reg(1, v); chk("R9 result unchanged when idle", v, 255);

      // Continuous, base 6 (channels 6,7,0,1), gated enable
      nxt_vin[6] = 8'd200; nxt_vin[7] = 8'd1; nxt_vin[0] = 8'd99; nxt_vin[1] = 8'd170;
      nxt_base = 3'd6; nxt_cont = 1'b1;
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      for (int i = 0; i < 420; i++) step(1'b0, (i % 3) != 0);
      chk("R8 done after first pass", int'(seq_done), 1);
      nxt_vin[7] = 8'd254;
      for (int i = 0; i < 420; i++) step(1'b0, (i % 3) != 0);
      chk("R8 done held in continuous", int'(seq_done), 1);
      chk("R9 still running in continuous", int'(m_run), 1);

      // R1: abort mid-sequence with enable low
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      chk("R1 done cleared by start", int'(seq_done), 0);
      for (int i = 0; i < 50; i++) step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      for (int i = 0; i < 140; i++) step(1'b0, 1'b1);
      read_reg(1, v); chk("R7 overwritten code ch7", v, 254);

      // Leave continuous mode: stops at end of current pass
      nxt_cont = 1'b0;
      for (int i = 0; i < 140; i++) step(1'b0, 1'b1);
      chk("R9 stopped after leaving continuous", int'(samp_en), 0);
      chk("R8 done kept after stop", int'(seq_done), 1);
      step(1'b0, 1'b1);

      summary();
   end

endmodule